// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

This block drives up to four interleaved pulse-width outputs for a multiphase buck controller. A free-running counter of `PERIOD` system clocks sets the switching period. The counter's zero point is the end of the channel-1 pulse. The other active channels end their pulses at evenly spaced points across the period. Two strap inputs choose whether two, three or four channels take part.

After a channel's pulse ends, its output is held low for a quarter of the period. This forced-off window gives the external current sense time to settle, and the block emits a one-cycle sample strobe for that channel `SETTLE` clocks into the window. Once the window has passed, the output rises on the first clock edge where the channel's compare input is high. The compare input is the digital form of "control level minus current correction has crossed the ramp". The output then stays high until the channel's next end-of-pulse event.

All pins are plain control signals. There is no data stream and no handshake. Parameters must satisfy `PERIOD >= 8` and `1 <= SETTLE < PERIOD/4`.

Top module: `mpps_phase_seq`

## Requirements
- R1: While `rst` is high at a clock edge, all `pwm` and `sample_stb` bits go low and every forced-off window is cleared. The period count restarts, so channel 1 ends its pulse at the first edge after `rst` falls.
- R2: The active channel count N is decoded from the straps. `two_ch_strap` high gives N=2 (bits 0 and 1). Otherwise `three_ch_strap` high gives N=3 (bits 0 to 2). With both straps low, N=4. With both straps high, N=2.
- R3: The period count runs 0 to PERIOD-1 and advances once per edge; count 0 falls at the first edge after reset. Channel bit k (k < N) ends its pulse at the edge where the count equals floor(PERIOD*k/N).
- R4: Channel 1 (bit 0) ends its pulse exactly once every PERIOD edges.
- R5: At an end-of-pulse edge the channel's output is driven low, whatever its compare input is.
- R6: After an end-of-pulse edge E, the output stays low through edge E+PERIOD/4-1. The compare input is ignored in that window.
- R7: From edge E+PERIOD/4 on, the output of an active channel rises at the first edge where its `cmp_fire` bit is high. It then stays high, whatever `cmp_fire` does, until its next end-of-pulse edge.
- R8: `sample_stb` bit k is high for exactly one cycle, the cycle that follows edge E+SETTLE.
- R9: The `pwm` and `sample_stb` bits of an inactive channel (k >= N) are low from the first edge at which it is inactive. Its window is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| two_ch_strap | input | 1 | Strap: select two-channel operation |
| three_ch_strap | input | 1 | Strap: select three-channel operation |
| cmp_fire | input | 4 | Per-channel compare result, high when the adjusted level has crossed the ramp |
| pwm | output | 4 | Per-channel pulse-width outputs |
| sample_stb | output | 4 | Per-channel current sample strobe |

## Verification
The delicate coincidence is an end-of-pulse event on the same edge where the compare input is high. The same risk arises where the last cycle of the forced-off window meets a high compare input. The bench provokes both by holding `cmp_fire` high for whole periods and by switching the straps while channels are mid-window. It judges them against a per-edge expected model: the falling edge must win, and the output may rise no earlier than PERIOD/4 edges after it.

// File: rtl/mpps_pkg.sv
package mpps_pkg;
  localparam int unsigned MAX_PHASES = 4;

  typedef enum logic [1:0] {
    PH_FOUR  = 2'd0,
    PH_THREE = 2'd1,
    PH_TWO   = 2'd2
  } phase_mode_e;

  function automatic int unsigned phase_count(phase_mode_e m);
    case (m)
      PH_TWO:   return 2;
      PH_THREE: return 3;
      default:  return 4;
    endcase
  endfunction

  // end-of-pulse count for leg k when n legs share the period
  function automatic int unsigned term_point(int unsigned period, int unsigned k, int unsigned n);
    if (k >= n) return 0;
    return (period * k) / n;
  endfunction
endpackage

// File: rtl/mpps_mode_decode.sv
module mpps_mode_decode
  import mpps_pkg::*;
(
  input  logic                  two_strap,
  input  logic                  three_strap,
  output phase_mode_e           mode,
  output logic [MAX_PHASES-1:0] active
);
  // the two-channel strap wins, which also covers both straps high
  always_comb begin
    if (two_strap)        mode = PH_TWO;
    else if (three_strap) mode = PH_THREE;
    else                  mode = PH_FOUR;
  end

  for (genvar k = 0; k < MAX_PHASES; k++) begin : g_act
    assign active[k] = (k < phase_count(mode));
  end
endmodule

// File: rtl/mpps_phase_clock.sv
module mpps_phase_clock
  import mpps_pkg::*;
#(
  parameter int unsigned PERIOD = 240,
  localparam int unsigned CW = $clog2(PERIOD)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  phase_mode_e           mode,
  input  logic [MAX_PHASES-1:0] active,
  output logic [CW-1:0]         cnt,
  output logic [MAX_PHASES-1:0] term
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end

  for (genvar k = 0; k < MAX_PHASES; k++) begin : g_leg
    localparam logic [CW-1:0] AT2 = CW'(term_point(PERIOD, k, 2));
    localparam logic [CW-1:0] AT3 = CW'(term_point(PERIOD, k, 3));
    localparam logic [CW-1:0] AT4 = CW'(term_point(PERIOD, k, 4));
    logic [CW-1:0] at;
    always_comb begin
      case (mode)
        PH_TWO:   at = AT2;
        PH_THREE: at = AT3;
        default:  at = AT4;
      endcase
    end
    assign term[k] = active[k] && (cnt == at);
  end
endmodule

// File: rtl/mpps_phase_leg.sv
module mpps_phase_leg #(
  parameter int unsigned QTR    = 60,
  parameter int unsigned SETTLE = 8,
  localparam int unsigned TW = $clog2(QTR)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic term,
  input  logic cmp,
  output logic pwm,
  output logic stb
);
  localparam logic [TW-1:0] LOAD   = TW'(QTR - 1);
  localparam logic [TW-1:0] STB_AT = TW'(QTR - SETTLE);

  logic [TW-1:0] tmr;
  logic          hold_off;

  assign hold_off = (tmr != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm <= 1'b0;
      stb <= 1'b0;
      tmr <= '0;
    end else begin
      stb <= active && (tmr == STB_AT);
      if (!active) begin
        pwm <= 1'b0;
        tmr <= '0;
      end else if (term) begin
        pwm <= 1'b0;
        tmr <= LOAD;
      end else if (hold_off) begin
        tmr <= tmr - TW'(1);
      end else if (cmp) begin
        pwm <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mpps_phase_seq.sv
module mpps_phase_seq
  import mpps_pkg::*;
#(
  parameter int unsigned PERIOD = 240,
  parameter int unsigned SETTLE = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            two_ch_strap,
  input  logic                            three_ch_strap,
  input  logic [mpps_pkg::MAX_PHASES-1:0] cmp_fire,
  output logic [mpps_pkg::MAX_PHASES-1:0] pwm,
  output logic [mpps_pkg::MAX_PHASES-1:0] sample_stb
);
  localparam int unsigned CW  = $clog2(PERIOD);
  localparam int unsigned QTR = PERIOD / 4;

  phase_mode_e           mode;
  logic [MAX_PHASES-1:0] active;
  logic [MAX_PHASES-1:0] term;
  logic [CW-1:0]         cnt;

  mpps_mode_decode u_dec (
    .two_strap  (two_ch_strap),
    .three_strap(three_ch_strap),
    .mode       (mode),
    .active     (active)
  );

  mpps_phase_clock #(.PERIOD(PERIOD)) u_clk (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .active(active),
    .cnt   (cnt),
    .term  (term)
  );

  for (genvar k = 0; k < MAX_PHASES; k++) begin : g_leg
    mpps_phase_leg #(.QTR(QTR), .SETTLE(SETTLE)) u_leg (
      .clk   (clk),
      .rst   (rst),
      .active(active[k]),
      .term  (term[k]),
      .cmp   (cmp_fire[k]),
      .pwm   (pwm[k]),
      .stb   (sample_stb[k])
    );
  end
endmodule

// File: rtl/mpps_phase_seq_chk.sv
module mpps_phase_seq_chk #(
  parameter int unsigned PERIOD = 240,
  localparam int unsigned CW = $clog2(PERIOD)
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    cmp_fire,
  input logic [3:0]    pwm,
  input logic [3:0]    sample_stb,
  input logic [3:0]    active,
  input logic [3:0]    term,
  input logic [CW-1:0] cnt
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (pwm == 4'b0) && (sample_stb == 4'b0));
  // R3
  single_term_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(term));
  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(PERIOD - 1));

  for (genvar k = 0; k < 4; k++) begin : g_leg
    // R5
    term_low_chk: assert property (@(posedge clk) disable iff (rst) term[k] |=> !pwm[k]);
    // R6
    min_off_chk: assert property (@(posedge clk) disable iff (rst) $fell(pwm[k]) |=> !pwm[k]);
    // R7
    rise_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(pwm[k]) |-> $past(cmp_fire[k]));
    // R8
    stb_pulse_chk: assert property (@(posedge clk) disable iff (rst) sample_stb[k] |=> !sample_stb[k]);
    // R9
    idle_leg_chk: assert property (@(posedge clk) disable iff (rst) !active[k] |=> !pwm[k] && !sample_stb[k]);
  end
endmodule

bind mpps_phase_seq mpps_phase_seq_chk #(.PERIOD(PERIOD)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmp_fire  (cmp_fire),
  .pwm       (pwm),
  .sample_stb(sample_stb),
  .active    (active),
  .term      (term),
  .cnt       (cnt)
);

// File: tb/mpps_phase_seq_test.sv
module mpps_phase_seq_test;
  localparam int P  = 48;
  localparam int ST = 5;
  localparam int Q  = P / 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       two_ch_strap = 1'b0;
  logic       three_ch_strap = 1'b0;
  logic [3:0] cmp_fire = 4'b0;
  logic [3:0] pwm;
  logic [3:0] sample_stb;

  int total = 0;
  int fails = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  // expected model state
  int    m_cnt = 0;
  bit [3:0] m_pwm = 4'b0;
  bit [3:0] m_stb = 4'b0;
  int    m_tmr [4] = '{0, 0, 0, 0};
  string m_tag [4] = '{"R1", "R1", "R1", "R1"};

  // observation
  int falls0 = 0;
  bit prev0 = 1'b0;
  bit [3:0] seen_high = 4'b0;

  always #10 clk = ~clk;

  mpps_phase_seq #(.PERIOD(P), .SETTLE(ST)) uut (
    .clk(clk), .rst(rst), .two_ch_strap(two_ch_strap), .three_ch_strap(three_ch_strap),
    .cmp_fire(cmp_fire), .pwm(pwm), .sample_stb(sample_stb)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int legs_from_straps(bit two, bit three);
    if (two) return 2;     // R2: two-channel strap wins
    if (three) return 3;
    return 4;
  endfunction

  always @(posedge clk) begin
    int n;
    bit [3:0] nstb;
    n = legs_from_straps(two_ch_strap, three_ch_strap);
    if (rst) begin
      m_cnt = 0; m_pwm = 4'b0; m_stb = 4'b0;
      for (int k = 0; k < 4; k++) begin m_tmr[k] = 0; m_tag[k] = "R1"; end
    end else begin
      for (int k = 0; k < 4; k++) begin
        bit act;
        act = (k < n);
        nstb[k] = act && (m_tmr[k] == Q - ST);
        if (!act) begin
          m_pwm[k] = 1'b0; m_tmr[k] = 0; m_tag[k] = "R9";
        end else if (m_cnt == (P * k) / n) begin
          m_pwm[k] = 1'b0; m_tmr[k] = Q - 1; m_tag[k] = "R3 R5";
        end else if (m_tmr[k] != 0) begin
          m_tmr[k]--; m_tag[k] = "R6";
        end else begin
          if (cmp_fire[k]) m_pwm[k] = 1'b1;
          m_tag[k] = "R7";
        end
      end
      m_stb = nstb;
      m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      for (int k = 0; k < 4; k++) begin
        check(pwm[k] == m_pwm[k], m_tag[k], $sformatf("pwm[%0d]", k), pwm[k], m_pwm[k]);
        check(sample_stb[k] == m_stb[k], (m_tag[k] == "R9") ? "R9" : "R8",
              $sformatf("sample_stb[%0d]", k), sample_stb[k], m_stb[k]);
      end
      if (prev0 && !pwm[0]) falls0++;
      prev0 = pwm[0];
      seen_high = seen_high | pwm;
    end
  end

  task automatic run_random(int cycles, int density);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) cmp_fire[k] = (($urandom % 8) < density);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(posedge clk);
    started = 1'b1;
    repeat (3) @(negedge clk);
    check(pwm == 4'b0, "R1", "pwm in reset", pwm, 0);
    check(sample_stb == 4'b0, "R1", "strobe in reset", sample_stb, 0);
    rst = 1'b0;

    // four legs, random compare
    run_random(400, 3);

    // R4: compare held high, channel 1 ends once per period
    @(negedge clk); cmp_fire = 4'hF;
    repeat (P) @(negedge clk);
    falls0 = 0;
    repeat (5 * P) @(negedge clk);
    check(falls0 == 5, "R4", "channel 1 ends per 5 periods", falls0, 5);

    // R2: three-leg strap
    three_ch_strap = 1'b1;
    repeat (2) @(negedge clk);
    seen_high = 4'b0;
    repeat (2 * P) @(negedge clk);
    check(seen_high == 4'b0111, "R2", "legs high with three strap", seen_high, 4'b0111);

    // R2: both straps high falls back to two legs
    two_ch_strap = 1'b1;
    repeat (2) @(negedge clk);
    seen_high = 4'b0;
    repeat (2 * P) @(negedge clk);
    check(seen_high == 4'b0011, "R2", "legs high with both straps", seen_high, 4'b0011);

    // random strap changes mid-window, mixed densities
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      two_ch_strap = $urandom % 2;
      three_ch_strap = $urandom % 2;
      run_random(150 + ($urandom % 100), 1 + s % 7);
      if (s == 4) begin
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check(pwm == 4'b0, "R1", "pwm in mid-run reset", pwm, 0);
        rst = 1'b0;
      end
    end

    // coincidence: compare high through an end-of-pulse edge
    two_ch_strap = 1'b0; three_ch_strap = 1'b0;
    @(negedge clk); cmp_fire = 4'hF;
    repeat (3 * P) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL R4 watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule